// File: doc/BRIEF.md
# EEPROM Page Write Buffer Controller

This block sits behind the serial slave engine of a small EEPROM and owns the write path. It gets the engine's decoded events: a Start strobe, an address strobe that carries the byte address, data bytes on a valid/ready stream, every Stop together with the bit-slot number at which it arrived, and the level of the write-control input. It collects up to one page of bytes and decides the Ack or NoAck answer for each byte. The collected bytes reach the internal register array only when a Stop lands in the slot that follows a data-byte Ack. After such a commit it holds a busy flag for a fixed number of clocks.

A write starts with a Start, then one address byte. Its upper bits choose the page and its low bits choose the first in-page offset. Each data byte goes to the current offset. Only the offset bits then step, so a long burst wraps back to the start of the same page. If write-control is high at any sampled clock from the Start through the address byte, the transaction is protected. In that case every data byte gets a NoAck and nothing is stored. Any Start or Stop throws the collected data away, unless that Stop commits it. A read port on the array lets the surrounding logic, and the bench, see the stored contents.

The data input is a valid/ready stream. A byte is taken in the cycle where `byte_valid_i` and `byte_ready_o` are both high. `byte_ready_o` is low for the whole internal write time. A byte that is presented then stays waiting and is not taken. Every taken byte gets exactly one answer on `ack_valid_o`/`ack_o`. That answer has no back-pressure.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, `busy_o` and `ack_valid_o` are 0, `byte_ready_o` is 1 and every array byte reads 0.
- R2: After Start and an address A, successive acknowledged bytes are stored at offsets A[3:0], A[3:0]+1, ... of page A[7:4], and a commit writes them there.
- R3: Only the 4-bit offset increments, modulo 16. A 17th or later byte wraps to the page start, and the last value sent to an offset is the one committed.
- R4: If `wc_i` is 1 at any clock edge from the Start cycle through the address cycle (inclusive), every data byte of that transaction answers `ack_o`=0 and no array byte changes.
- R5: Each byte taken by the handshake produces exactly one `ack_valid_o` pulse on the next cycle. `ack_o`=1 there only if the transaction is in its data phase and is not protected.
- R6: A commit happens only for a Stop with `stop_slot_i`==10, in the data phase, with at least one acknowledged byte. A Stop in any other slot discards the bytes and leaves `busy_o` low.
- R7: A commit raises `busy_o` on the cycle after the Stop and holds it for exactly WRITE_CYCLES cycles. `byte_ready_o` is 0 throughout.
- R8: While `busy_o` is 1, Start, address, byte and Stop inputs have no effect: no ack pulse, no phase change and no array change.
- R9: A commit writes only the offsets that received an acknowledged byte. Other bytes of the page keep their values.
- R10: A Start clears the collected bytes. A Start before any data byte (random-read setup), or a repeated Start after data, leaves the array unchanged.
- R11: `wc_i` changes after the address byte do not affect the Ack answer or the commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start condition seen (one-cycle strobe) |
| addr_valid_i | input | 1 | Byte address received |
| addr_i | input | ADDR_W | Byte address |
| byte_valid_i | input | 1 | Data byte offered |
| byte_i | input | 8 | Data byte |
| byte_ready_o | output | 1 | Data byte can be taken (low while busy) |
| ack_valid_o | output | 1 | Answer for the byte taken last cycle |
| ack_o | output | 1 | 1 = Ack, 0 = NoAck |
| stop_i | input | 1 | Stop condition seen (one-cycle strobe) |
| stop_slot_i | input | 4 | Bit slot of that Stop within the current byte frame |
| wc_i | input | 1 | Write-control level, 1 = protect |
| busy_o | output | 1 | Internal write cycle running |
| rd_addr_i | input | ADDR_W | Array read address |
| rd_data_o | output | 8 | Array byte at `rd_addr_i` (combinational) |

## Verification
The answer to a byte appears one cycle after its handshake edge. A queue holds the answer expected for each byte, and a monitor compares `ack_valid_o`/`ack_o` at every falling edge, so a missing, extra or wrong answer is caught in the cycle it happens. A commit shows as `busy_o` high at the falling edge right after the Stop's rising edge. The bench then counts falling edges until busy drops and expects exactly WRITE_CYCLES. Array contents come through the combinational read port and are compared with a bench model that is updated by the requirement rules only.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_t;
endpackage

// File: rtl/pwb_wc_window.sv
// Write-protect latch: collects the write-control level from Start
// through the address byte, then holds it until the next Start.
module pwb_wc_window (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic window_i,
  input  logic wc_i,
  output logic protect_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        protect_o <= 1'b0;
    else if (start_i)  protect_o <= wc_i;
    else if (window_i) protect_o <= protect_o | wc_i;
  end
endmodule

// File: rtl/pwb_page_buf.sv
// One page of collected bytes, a per-offset fill mask and the in-page offset counter.
module pwb_page_buf #(
  parameter int PAGE_BYTES = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear_i,
  input  logic                    load_i,
  input  logic [$clog2(PAGE_BYTES)-1:0] off_i,
  input  logic                    wr_i,
  input  logic [7:0]              byte_i,
  output logic [PAGE_BYTES*8-1:0] data_o,
  output logic [PAGE_BYTES-1:0]   mask_o
);
  localparam int OFF_W = $clog2(PAGE_BYTES);

  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      off_q <= '0;
    else if (load_i) off_q <= off_i;
    else if (wr_i)   off_q <= off_q + 1'b1;
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic hit;
    assign hit = wr_i && (off_q == OFF_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_o[g*8 +: 8] <= '0;
        mask_o[g]        <= 1'b0;
      end else begin
        if (hit) data_o[g*8 +: 8] <= byte_i;
        if (clear_i)  mask_o[g] <= 1'b0;
        else if (hit) mask_o[g] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwb_write_timer.sv
// Internal write-time counter; busy while non-zero.
module pwb_write_timer #(
  parameter int CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (fire_i)        cnt_q <= CNT_W'(CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/pwb_array.sv
// Register array; a commit writes the masked bytes of one page in a single cycle.
module pwb_array #(
  parameter int ADDR_W     = 8,
  parameter int PAGE_BYTES = 16
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  commit_i,
  input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0]  page_i,
  input  logic [PAGE_BYTES*8-1:0]               data_i,
  input  logic [PAGE_BYTES-1:0]                 mask_i,
  input  logic [ADDR_W-1:0]                     rd_addr_i,
  output logic [7:0]                            rd_data_o
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [7:0] cells [DEPTH];

  for (genvar r = 0; r < DEPTH; r++) begin : g_row
    localparam int ROW_PAGE = r / PAGE_BYTES;
    localparam int ROW_OFF  = r % PAGE_BYTES;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cells[r] <= '0;
      else if (commit_i && page_i == PAGE_W'(ROW_PAGE) && mask_i[ROW_OFF])
        cells[r] <= data_i[ROW_OFF*8 +: 8];
    end
  end

  assign rd_data_o = cells[rd_addr_i];
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import pwb_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 20,
  parameter int COMMIT_SLOT  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              addr_valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  output logic              byte_ready_o,
  output logic              ack_valid_o,
  output logic              ack_o,
  input  logic              stop_i,
  input  logic [3:0]        stop_slot_i,
  input  logic              wc_i,
  output logic              busy_o,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFF_W;

  phase_t                  phase_q;
  logic                    live, start_ev, addr_ev, stop_ev, byte_fire, store, commit;
  logic                    protect;
  logic [PAGE_W-1:0]       page_q;
  logic [PAGE_BYTES*8-1:0] buf_data;
  logic [PAGE_BYTES-1:0]   buf_mask;

  // All bus-side events are dropped during the internal write time.
  assign live      = !busy_o;
  assign start_ev  = live && start_i;
  assign stop_ev   = live && stop_i && !start_i;
  assign addr_ev   = live && addr_valid_i && phase_q == PH_ADDR && !start_i;
  assign byte_fire = byte_valid_i && byte_ready_o;
  assign store     = byte_fire && phase_q == PH_DATA && !protect && !start_i && !stop_i;
  assign commit    = stop_ev && phase_q == PH_DATA && stop_slot_i == 4'(COMMIT_SLOT)
                     && (|buf_mask) && !protect;

  assign byte_ready_o = live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      page_q  <= '0;
    end else if (start_ev) begin
      phase_q <= PH_ADDR;
    end else if (stop_ev) begin
      phase_q <= PH_IDLE;
    end else if (addr_ev) begin
      phase_q <= PH_DATA;
      page_q  <= addr_i[ADDR_W-1:OFF_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_valid_o <= 1'b0;
      ack_o       <= 1'b0;
    end else begin
      ack_valid_o <= byte_fire;
      ack_o       <= store;
    end
  end

  pwb_wc_window u_wc (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_ev),
    .window_i  (live && phase_q == PH_ADDR),
    .wc_i      (wc_i),
    .protect_o (protect)
  );

  pwb_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (start_ev || stop_ev),
    .load_i  (addr_ev),
    .off_i   (addr_i[OFF_W-1:0]),
    .wr_i    (store),
    .byte_i  (byte_i),
    .data_o  (buf_data),
    .mask_o  (buf_mask)
  );

  pwb_write_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire_i (commit),
    .busy_o (busy_o)
  );

  pwb_array #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit_i  (commit),
    .page_i    (page_q),
    .data_i    (buf_data),
    .mask_i    (buf_mask),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
  parameter int WRITE_CYCLES = 20,
  parameter int COMMIT_SLOT  = 10
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy_o,
  input logic       byte_valid_i,
  input logic       byte_ready_o,
  input logic       ack_valid_o,
  input logic       ack_o,
  input logic       stop_i,
  input logic [3:0] stop_slot_i
);
  logic [31:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_run <= '0;
    else if (busy_o) busy_run <= busy_run + 1;
    else             busy_run <= '0;
  end

  AST_ACK_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid_o |-> $past(byte_valid_i && byte_ready_o)); // R5

  AST_ACK_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> ack_valid_o); // R5

  AST_COMMIT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(stop_i && stop_slot_i == 4'(COMMIT_SLOT))); // R6

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> busy_run == WRITE_CYCLES); // R7

  AST_BUSY_NO_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> !ack_valid_o); // R8
endmodule

bind eeprom_page_writer pwb_checker #(
  .WRITE_CYCLES (WRITE_CYCLES),
  .COMMIT_SLOT  (COMMIT_SLOT)
) u_pwb_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy_o       (busy_o),
  .byte_valid_i (byte_valid_i),
  .byte_ready_o (byte_ready_o),
  .ack_valid_o  (ack_valid_o),
  .ack_o        (ack_o),
  .stop_i       (stop_i),
  .stop_slot_i  (stop_slot_i)
);

// File: tb/eeprom_page_writer_test.sv
module eeprom_page_writer_test;
  localparam int W = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 0, addr_valid_i = 0, byte_valid_i = 0, stop_i = 0, wc_i = 0;
  logic [7:0] addr_i = 0, byte_i = 0, rd_addr_i = 0;
  logic [3:0] stop_slot_i = 0;
  logic       byte_ready_o, ack_valid_o, ack_o, busy_o;
  logic [7:0] rd_data_o;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model
  logic [7:0] model [256];
  logic [7:0] sh_data [16];
  bit         sh_mask [16];
  int         tb_ph = 0;
  bit         tb_prot = 0;
  logic [3:0] tb_page = 0, tb_off = 0;
  bit         exp_q [$];

  always #2 clk = ~clk;

  eeprom_page_writer #(.WRITE_CYCLES(W)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_valid_i(addr_valid_i),
    .addr_i(addr_i), .byte_valid_i(byte_valid_i), .byte_i(byte_i),
    .byte_ready_o(byte_ready_o), .ack_valid_o(ack_valid_o), .ack_o(ack_o),
    .stop_i(stop_i), .stop_slot_i(stop_slot_i), .wc_i(wc_i), .busy_o(busy_o),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: every answer pulse is compared against the queue (R5)
  always @(negedge clk) begin
    if (rst_n && ack_valid_o) begin
      if (exp_q.size() == 0) check(0, "R5/R8 unexpected ack pulse", 1, 0);
      else begin
        bit e;
        e = exp_q.pop_front();
        check(ack_o == e, "R5 ack value", ack_o, e);
      end
    end
  end

  task automatic wc_track();
    if (tb_ph == 1 && wc_i) tb_prot = 1;
  endtask

  task automatic do_start();
    start_i = 1;
    @(posedge clk);
    tb_ph = 1; tb_prot = wc_i;
    for (int i = 0; i < 16; i++) sh_mask[i] = 0;
    @(negedge clk); start_i = 0;
  endtask

  task automatic do_addr(input logic [7:0] a);
    addr_valid_i = 1; addr_i = a;
    @(posedge clk);
    wc_track();
    if (tb_ph == 1) begin tb_ph = 2; tb_page = a[7:4]; tb_off = a[3:0]; end
    @(negedge clk); addr_valid_i = 0;
  endtask

  task automatic set_wc(input bit v);
    wc_i = v;
    @(posedge clk);
    wc_track();
    @(negedge clk);
  endtask

  task automatic do_byte(input logic [7:0] v);
    bit a;
    a = (tb_ph == 2) && !tb_prot;
    exp_q.push_back(a);
    byte_valid_i = 1; byte_i = v;
    @(posedge clk);
    wc_track();
    if (a) begin sh_data[tb_off] = v; sh_mask[tb_off] = 1; tb_off = tb_off + 1; end
    @(negedge clk); byte_valid_i = 0;
  endtask

  task automatic do_stop(input logic [3:0] slot, input string tag);
    bit any = 0, c;
    for (int i = 0; i < 16; i++) any |= sh_mask[i];
    c = (tb_ph == 2) && (slot == 10) && any && !tb_prot;
    stop_i = 1; stop_slot_i = slot;
    @(posedge clk);
    if (c) for (int i = 0; i < 16; i++) if (sh_mask[i]) model[{tb_page, 4'(i)}] = sh_data[i];
    tb_ph = 0;
    for (int i = 0; i < 16; i++) sh_mask[i] = 0;
    @(negedge clk); stop_i = 0;
    check(busy_o == c, {tag, " busy after stop"}, busy_o, c);
  endtask

  task automatic wait_busy(input bit check_len);
    int n = 0;
    while (busy_o && n < 1000) begin
      if (n == 0) check(byte_ready_o == 0, "R7 ready low while busy", byte_ready_o, 0);
      n++;
      @(negedge clk);
    end
    if (check_len) check(n == W, "R7 busy length", n, W);
  endtask

  task automatic verify_mem(input string tag);
    int bad = 0, first = -1, act = 0, exp = 0;
    for (int a = 0; a < 256; a++) begin
      rd_addr_i = 8'(a);
      #0.1;
      if (rd_data_o !== model[a]) begin
        if (first < 0) begin first = a; act = rd_data_o; exp = model[a]; end
        bad++;
      end
    end
    check(bad == 0, tag, act, exp);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      check(0, "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(busy_o == 0, "R1 busy at reset", busy_o, 0);
    check(byte_ready_o == 1, "R1 ready at reset", byte_ready_o, 1);
    check(ack_valid_o == 0, "R1 no ack at reset", ack_valid_o, 0);
    verify_mem("R1 array cleared");

    // R2 R9 three-byte page write
    do_start(); do_addr(8'h12);
    do_byte(8'h5A); do_byte(8'hC3); do_byte(8'h7E);
    do_stop(4'd10, "R6 commit");
    wait_busy(1);
    verify_mem("R2 R9 bytes placed, neighbours kept");

    // R3 wrap within page, last value wins
    do_start(); do_addr(8'h3E);
    for (int i = 0; i < 18; i++) do_byte(8'hA0 + 8'(i));
    do_stop(4'd10, "R3 commit");
    wait_busy(1);
    check(model[8'h3E] == 8'hB0, "R3 bench model wrap offset E", model[8'h3E], 8'hB0);
    verify_mem("R3 wrap result");

    // R4 wc high for one cycle inside the window
    do_start(); set_wc(1); set_wc(0); do_addr(8'h44);
    do_byte(8'h11); do_byte(8'h22);
    do_stop(4'd10, "R4 protected");
    verify_mem("R4 array untouched");

    // R4 wc high only at the address cycle
    do_start(); wc_i = 1; do_addr(8'h48); wc_i = 0;
    do_byte(8'h33);
    do_stop(4'd10, "R4 protected at address");
    verify_mem("R4 array untouched 2");

    // R11 wc high after address does not matter
    do_start(); do_addr(8'h50); set_wc(1);
    do_byte(8'h9D); do_byte(8'h9E);
    wc_i = 0;
    do_stop(4'd10, "R11 commit");
    wait_busy(1);
    verify_mem("R11 written despite late wc");

    // R6 stop in a wrong slot discards
    do_start(); do_addr(8'h60); do_byte(8'hEE);
    do_stop(4'd9, "R6 slot 9");
    do_start(); do_addr(8'h61); do_byte(8'hEF);
    do_stop(4'd1, "R6 slot 1");
    verify_mem("R6 array untouched");

    // R10 random-read setup and repeated start
    do_start(); do_addr(8'h70); do_start();
    do_stop(4'd10, "R10 no data");
    do_start(); do_addr(8'h80); do_byte(8'h01); do_start();
    do_stop(4'd10, "R10 repeated start");
    do_start(); do_addr(8'h90); do_byte(8'h42);
    do_stop(4'd10, "R10 fresh write");
    // R8 events during busy are ignored
    check(byte_ready_o == 0, "R8 ready low in busy", byte_ready_o, 0);
    start_i = 1; @(negedge clk); start_i = 0;
    addr_valid_i = 1; addr_i = 8'hA0; @(negedge clk); addr_valid_i = 0;
    byte_valid_i = 1; byte_i = 8'h77; @(negedge clk); byte_valid_i = 0;
    stop_i = 1; stop_slot_i = 4'd10; @(negedge clk); stop_i = 0;
    wait_busy(0);
    @(negedge clk);
    check(busy_o == 0, "R8 no commit from busy-time traffic", busy_o, 0);
    verify_mem("R8 R10 array contents");
    // phase stayed idle: a byte now answers NoAck (R8)
    do_byte(8'h55);
    do_stop(4'd10, "R8 idle stop");
    verify_mem("R8 idle byte not stored");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R5 all answers seen", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule